// File: doc/BRIEF.md
# Miscellaneous System Control Register Bank

This block is a small bank of byte and word control registers for a workstation I/O controller. A host reaches it over a plain bus with an address, write data and a write enable, and reads back through a registered read-data port. One address window is decoded into five registers: configuration, diagnostic, modem control, a 16-bit diagnostic LED word and a system control word. Two auxiliary registers are reached through separate select strobes instead of the address. These strobes override the address decode.

Two registers have side effects when written. Writing the first auxiliary register with its low bit set sends a one-clock terminal-count pulse to a floppy controller. Writing the system control word with its low bit set loads a reset-status value and raises a one-clock system reset request. The block reset clears only some registers. The diagnostic, LED and system control contents survive it, so software can see after a restart that the restart came from a reset request.

Top module: `sysmisc_regbank`

## Requirements
- R1: The register is chosen by `addr & 0x0FFF0000`. 0x01800000 selects configuration, 0x01A00000 diagnostic, 0x01B00000 modem control, 0x01600000 LED and 0x01F00000 system control. Bits outside the mask are ignored. Any other masked value reads as zero, and writes to it change no register.
- R2: The configuration, diagnostic, modem control and second auxiliary registers store `wdata[7:0]` on a write. They read back zero-extended to 32 bits.
- R3: The LED register holds `wdata[15:0]` and is hit only when `addr[0]` is 0. The system control register is hit only when `addr[1:0]` is 0. Other sub-offsets read zero, and writes to them are ignored.
- R4: Asserting `rst_n` low clears configuration, modem control and both auxiliary registers to zero. It also clears `rdata`.
- R5: Reset leaves the diagnostic, LED and system control registers unchanged.
- R6: A system control write with `wdata[0]`=1 loads the register with 0x02 and drives `sys_rst_req` high for exactly the next clock. A write with `wdata[0]`=0 changes nothing and gives no pulse.
- R7: A write to auxiliary-1 stores `wdata[7:0]` with bit 0 forced to 0. If `wdata[0]` is 1, `tc_pulse` is high for exactly the clock after the write.
- R8: When `aux1_sel` is high, an access goes to auxiliary-1 whatever `addr` holds. Otherwise, when `aux2_sel` is high, it goes to auxiliary-2. `aux1_sel` has priority.
- R9: `rdata` shows the register addressed in one cycle on the next cycle. Reads have no side effects.
- R10: `tc_pulse` and `sys_rst_req` are low during reset and whenever no qualifying write took place in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Access address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write enable for the current cycle |
| aux1_sel | input | 1 | Routes the access to auxiliary-1 |
| aux2_sel | input | 1 | Routes the access to auxiliary-2 |
| rdata | output | 32 | Registered read data |
| tc_pulse | output | 1 | One-clock floppy terminal-count pulse |
| sys_rst_req | output | 1 | One-clock system reset request |

## Verification
The hardest state to reach is a reset that partly clears the bank. To be checked, the registers that survive it must hold values that differ from whatever the cleared ones hold. The stimulus first writes a distinct value into every register, including the reset-status value produced by a reset-request write. It then pulls `rst_n` low in the middle of the run and reads each register back, so surviving and cleared contents are told apart at the read port. Sub-offset aliases and strobe priority are reached by writing through an alias or a competing strobe and then reading the register that the write must not have touched.

// File: rtl/sysmisc_pkg.sv
package sysmisc_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int LED_W     = 16;
    localparam int SYS_W     = 8;
    localparam int LED_SUB_W = 1;   // LED word: low address bit must be zero
    localparam int SYS_SUB_W = 2;   // system word: low two address bits must be zero
    localparam int TC_BIT    = 0;
    localparam int RST_BIT   = 0;

    localparam logic [ADDR_W-1:0] WIN_MASK = 32'h0FFF_0000;
    localparam logic [ADDR_W-1:0] OFS_LED  = 32'h0160_0000;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 32'h0180_0000;
    localparam logic [ADDR_W-1:0] OFS_DIAG = 32'h01A0_0000;
    localparam logic [ADDR_W-1:0] OFS_MDM  = 32'h01B0_0000;
    localparam logic [ADDR_W-1:0] OFS_SYS  = 32'h01F0_0000;

    localparam logic [SYS_W-1:0]  SYS_RST_STAT = 8'h02;
    localparam logic [BYTE_W-1:0] TC_CLR_MASK  = ~(BYTE_W'(1) << TC_BIT);

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CFG, SEL_DIAG, SEL_MDM, SEL_LED, SEL_SYS, SEL_AUX1, SEL_AUX2
    } reg_sel_e;

    // State cleared by the block reset
    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] mdm;
        logic [BYTE_W-1:0] aux1;
        logic [BYTE_W-1:0] aux2;
        logic [DATA_W-1:0] rdata;
        logic              tc;
        logic              rst_req;
    } clr_regs_t;

    // State that survives the block reset
    typedef struct packed {
        logic [BYTE_W-1:0] diag;
        logic [LED_W-1:0]  led;
        logic [SYS_W-1:0]  sys;
    } keep_regs_t;
endpackage

// File: rtl/sysmisc_decode.sv
module sysmisc_decode
    import sysmisc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              aux1_sel,
    input  logic              aux2_sel,
    output reg_sel_e          sel
);
    logic [ADDR_W-1:0] win;
    logic              led_sub_ok;
    logic              sys_sub_ok;

    assign win        = addr & WIN_MASK;
    assign led_sub_ok = (addr[LED_SUB_W-1:0] == '0);
    assign sys_sub_ok = (addr[SYS_SUB_W-1:0] == '0);

    always_comb begin
        sel = SEL_NONE;
        if (aux1_sel) begin
            sel = SEL_AUX1;
        end else if (aux2_sel) begin
            sel = SEL_AUX2;
        end else if (win == OFS_CFG) begin
            sel = SEL_CFG;
        end else if (win == OFS_DIAG) begin
            sel = SEL_DIAG;
        end else if (win == OFS_MDM) begin
            sel = SEL_MDM;
        end else if (win == OFS_LED && led_sub_ok) begin
            sel = SEL_LED;
        end else if (win == OFS_SYS && sys_sub_ok) begin
            sel = SEL_SYS;
        end
    end
endmodule

// File: rtl/sysmisc_rdmux.sv
module sysmisc_rdmux
    import sysmisc_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] cfg,
    input  logic [BYTE_W-1:0] diag,
    input  logic [BYTE_W-1:0] mdm,
    input  logic [BYTE_W-1:0] aux1,
    input  logic [BYTE_W-1:0] aux2,
    input  logic [LED_W-1:0]  led,
    input  logic [SYS_W-1:0]  sys,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        word = '0;
        case (sel)
            SEL_CFG:  word = DATA_W'(cfg);
            SEL_DIAG: word = DATA_W'(diag);
            SEL_MDM:  word = DATA_W'(mdm);
            SEL_AUX1: word = DATA_W'(aux1);
            SEL_AUX2: word = DATA_W'(aux2);
            SEL_LED:  word = DATA_W'(led);
            SEL_SYS:  word = DATA_W'(sys);
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/sysmisc_regbank.sv
module sysmisc_regbank
    import sysmisc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              aux1_sel,
    input  logic              aux2_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              tc_pulse,
    output logic              sys_rst_req
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_word;
    clr_regs_t         clr_d, clr_q;
    keep_regs_t        keep_d, keep_q;
    logic              wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:LED_W];

    sysmisc_decode u_decode (
        .addr     (addr),
        .aux1_sel (aux1_sel),
        .aux2_sel (aux2_sel),
        .sel      (sel)
    );

    sysmisc_rdmux u_rdmux (
        .sel  (sel),
        .cfg  (clr_q.cfg),
        .diag (keep_q.diag),
        .mdm  (clr_q.mdm),
        .aux1 (clr_q.aux1),
        .aux2 (clr_q.aux2),
        .led  (keep_q.led),
        .sys  (keep_q.sys),
        .word (rd_word)
    );

    always_comb begin
        clr_d         = clr_q;
        keep_d        = keep_q;
        clr_d.rdata   = rd_word;
        clr_d.tc      = 1'b0;
        clr_d.rst_req = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_CFG:  clr_d.cfg   = wdata[BYTE_W-1:0];
                SEL_DIAG: keep_d.diag = wdata[BYTE_W-1:0];
                SEL_MDM:  clr_d.mdm   = wdata[BYTE_W-1:0];
                SEL_AUX2: clr_d.aux2  = wdata[BYTE_W-1:0];
                SEL_LED:  keep_d.led  = wdata[LED_W-1:0];
                SEL_AUX1: begin
                    clr_d.aux1 = wdata[BYTE_W-1:0] & TC_CLR_MASK;
                    clr_d.tc   = wdata[TC_BIT];
                end
                SEL_SYS: begin
                    if (wdata[RST_BIT]) begin
                        keep_d.sys    = SYS_RST_STAT;
                        clr_d.rst_req = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= '0;
        end else begin
            clr_q <= clr_d;
        end
    end

    always_ff @(posedge clk) begin
        keep_q <= keep_d;
    end

    assign rdata       = clr_q.rdata;
    assign tc_pulse    = clr_q.tc;
    assign sys_rst_req = clr_q.rst_req;
endmodule

// File: rtl/sysmisc_regbank_chk.sv
module sysmisc_regbank_chk
    import sysmisc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              aux1_sel,
    input logic              aux2_sel,
    input logic [DATA_W-1:0] rdata,
    input logic              tc_pulse,
    input logic              sys_rst_req
);
    logic [ADDR_W-1:0] win;
    logic              no_aux;
    logic              sys_hit;
    logic              no_hit;
    logic              wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:1];
    assign win     = addr & WIN_MASK;
    assign no_aux  = !aux1_sel && !aux2_sel;
    assign sys_hit = no_aux && (win == OFS_SYS) && (addr[SYS_SUB_W-1:0] == '0);
    assign no_hit  = no_aux && (win != OFS_CFG) && (win != OFS_DIAG) && (win != OFS_MDM)
                     && (win != OFS_LED) && (win != OFS_SYS);

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        no_hit |=> (rdata == '0));

    p_aux2_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux1_sel && aux2_sel) |=> (rdata[DATA_W-1:BYTE_W] == '0));

    p_rst_req_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sys_hit && wdata[RST_BIT]) |=> sys_rst_req);

    p_rst_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(wr_en && sys_hit && wdata[RST_BIT]));

    p_tc_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && aux1_sel && wdata[TC_BIT]) |=> tc_pulse);

    p_tc_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(wr_en && aux1_sel && wdata[TC_BIT]));

    p_aux1_tc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aux1_sel |=> (rdata[TC_BIT] == 1'b0));
endmodule

bind sysmisc_regbank sysmisc_regbank_chk u_chk (.*);

// File: tb/sysmisc_regbank_test.sv
module sysmisc_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] A_LED  = 32'h0160_0000;
    localparam logic [31:0] A_CFG  = 32'h0180_0000;
    localparam logic [31:0] A_DIAG = 32'h01A0_0000;
    localparam logic [31:0] A_MDM  = 32'h01B0_0000;
    localparam logic [31:0] A_SYS  = 32'h01F0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        aux1_sel = 1'b0;
    logic        aux2_sel = 1'b0;
    logic [31:0] rdata;
    logic        tc_pulse;
    logic        sys_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysmisc_regbank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .aux1_sel(aux1_sel), .aux2_sel(aux2_sel), .rdata(rdata),
        .tc_pulse(tc_pulse), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; checks the pulses in the following cycle and that they drop after it
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic a1, input logic a2,
                      input logic exp_tc, input logic exp_rr);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; aux1_sel = a1; aux2_sel = a2;
        @(negedge clk);
        chk("R7 tc_pulse after write", 32'(tc_pulse), 32'(exp_tc));
        chk("R6 sys_rst_req after write", 32'(sys_rst_req), 32'(exp_rr));
        wr_en = 1'b0; aux1_sel = 1'b0; aux2_sel = 1'b0;
        @(negedge clk);
        chk("R10 pulses drop after one clock", {30'd0, tc_pulse, sys_rst_req}, 32'd0);
    endtask

    task automatic rd(input logic [31:0] a, input logic a1, input logic a2, output logic [31:0] v);
        @(negedge clk);
        addr = a; wr_en = 1'b0; aux1_sel = a1; aux2_sel = a2;
        @(negedge clk);
        v = rdata;
        chk("R9 read has no side effect", {30'd0, tc_pulse, sys_rst_req}, 32'd0);
        aux1_sel = 1'b0; aux2_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] regs [4];
        regs[0] = A_CFG; regs[1] = A_DIAG; regs[2] = A_MDM; regs[3] = A_DIAG;

        // Reset state
        repeat (3) @(negedge clk);
        chk("R4 rdata in reset", rdata, 32'd0);
        chk("R10 pulses low in reset", {30'd0, tc_pulse, sys_rst_req}, 32'd0);
        rst_n = 1'b1;

        // Reset request loads the status value
        wr(A_SYS, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1);
        rd(A_SYS, 1'b0, 1'b0, v);
        chk("R6 system word after request", v, 32'h0000_0002);

        // Byte register sweep (configuration, diagnostic, modem control, auxiliary-2)
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 256; i++) begin
                logic [31:0] d;
                d = {8'hC3, 8'(i) ^ 8'h3C, 8'h96, 8'(i)};
                if (r == 3) begin
                    wr(32'h0, d, 1'b0, 1'b1, 1'b0, 1'b0);
                    rd(32'h0, 1'b0, 1'b1, v);
                    chk("R2 auxiliary-2 readback", v, 32'(i));
                end else begin
                    wr(regs[r] + 32'(i % 7), d, 1'b0, 1'b0, 1'b0, 1'b0);
                    rd(regs[r], 1'b0, 1'b0, v);
                    chk("R2 byte register readback", v, 32'(i));
                end
            end
        end

        // Auxiliary-1 sweep: bit 0 is a pulse, not stored
        for (int i = 0; i < 256; i++) begin
            wr(32'h1234_5678, {24'hA5A5A5, 8'(i)}, 1'b1, 1'b0, 1'(i & 1), 1'b0);
            rd(32'h0, 1'b1, 1'b0, v);
            chk("R7 auxiliary-1 stored without bit 0", v, 32'(i & 32'hFE));
        end

        // LED word sweep and odd sub-offset alias
        for (int i = 0; i < 32; i++) begin
            logic [31:0] d;
            d = 32'(i) * 32'h9E37_79B1;
            wr(A_LED, d, 1'b0, 1'b0, 1'b0, 1'b0);
            rd(A_LED, 1'b0, 1'b0, v);
            chk("R3 LED readback", v, {16'd0, d[15:0]});
            wr(A_LED + 32'd1, ~d, 1'b0, 1'b0, 1'b0, 1'b0);
            rd(A_LED, 1'b0, 1'b0, v);
            chk("R3 LED unchanged by odd sub-offset write", v, {16'd0, d[15:0]});
            rd(A_LED + 32'd1, 1'b0, 1'b0, v);
            chk("R3 LED odd sub-offset reads zero", v, 32'd0);
        end

        // System word sub-offsets and bit-0-clear write
        for (int s = 1; s < 4; s++) begin
            wr(A_SYS + 32'(s), 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0);
            rd(A_SYS + 32'(s), 1'b0, 1'b0, v);
            chk("R3 system sub-offset reads zero", v, 32'd0);
        end
        wr(A_SYS, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(A_SYS, 1'b0, 1'b0, v);
        chk("R6 bit-0-clear write leaves system word", v, 32'h0000_0002);

        // Mask ignores bits outside the window
        wr(32'hF180_1234, 32'h0000_0077, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(A_CFG, 1'b0, 1'b0, v);
        chk("R1 configuration hit through masked address", v, 32'h77);

        // Unmapped offsets
        for (int u = 0; u < 4; u++) begin
            logic [31:0] ua;
            ua = (u == 0) ? 32'h0170_0000 : (u == 1) ? 32'h01C0_0000 :
                 (u == 2) ? 32'h0000_0000 : 32'h0190_0000;
            wr(ua, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
            rd(ua, 1'b0, 1'b0, v);
            chk("R1 unmapped reads zero", v, 32'd0);
            rd(A_CFG, 1'b0, 1'b0, v);
            chk("R1 unmapped write leaves configuration", v, 32'h77);
        end

        // Strobe priority
        wr(A_CFG, 32'h0000_0040, 1'b1, 1'b1, 1'b0, 1'b0);
        rd(32'h0, 1'b1, 1'b0, v);
        chk("R8 auxiliary-1 wins over auxiliary-2", v, 32'h40);
        rd(32'h0, 1'b0, 1'b1, v);
        chk("R8 auxiliary-2 untouched", v, 32'hFF);
        rd(A_CFG, 1'b0, 1'b0, v);
        chk("R8 configuration untouched by strobed write", v, 32'h77);
        wr(A_DIAG, 32'h0000_0011, 1'b0, 1'b1, 1'b0, 1'b0);
        rd(A_DIAG, 1'b0, 1'b0, v);
        chk("R8 diagnostic untouched by auxiliary-2 write", v, 32'hFF);

        // Partial reset
        wr(A_CFG,  32'h12, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(A_DIAG, 32'h34, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(A_MDM,  32'h56, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(32'h0,  32'h78, 1'b1, 1'b0, 1'b0, 1'b0);
        wr(32'h0,  32'h9A, 1'b0, 1'b1, 1'b0, 1'b0);
        wr(A_LED,  32'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(A_SYS,  32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 rdata cleared by reset", rdata, 32'd0);
        rst_n = 1'b1;
        rd(A_CFG, 1'b0, 1'b0, v);  chk("R4 configuration cleared", v, 32'd0);
        rd(A_MDM, 1'b0, 1'b0, v);  chk("R4 modem control cleared", v, 32'd0);
        rd(32'h0, 1'b1, 1'b0, v);  chk("R4 auxiliary-1 cleared", v, 32'd0);
        rd(32'h0, 1'b0, 1'b1, v);  chk("R4 auxiliary-2 cleared", v, 32'd0);
        rd(A_DIAG, 1'b0, 1'b0, v); chk("R5 diagnostic kept", v, 32'h34);
        rd(A_LED, 1'b0, 1'b0, v);  chk("R5 LED kept", v, 32'hBEEF);
        rd(A_SYS, 1'b0, 1'b0, v);  chk("R5 reset status kept", v, 32'h2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule